// File: doc/BRIEF.md
# Dual-Class Level Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines and steers each of them toward a normal-class request, a fast-class request, or both. Every source owns two independent enable bits, one per class. A source is pending in a class while its line is high and its enable for that class is set. Pending bits are never latched: they drop as soon as the line or the enable drops.

The lines first pass through a two-flop synchronizer. Each class request output is the OR of that class's pending bits, registered once in the bus clock domain. Software reaches two read/write enable registers and two read-only pending registers through a simple word-addressed register port. Every access gets a response one clock later. Only full 32-bit transfers are legal. A narrower access, or an access to an unmapped address, returns an error and changes nothing.

Top module: `irq_dual_router`

## Requirements
- R1: After reset both enable registers and both pending registers read as zero, and both request outputs are low.
- R2: The normal enable register sits at address 0x04 and the fast enable register at 0x08. Both are read/write, and a word write (busSize = 2'b10) stores all 32 bits, which a later read returns.
- R3: The normal pending register at 0x0C reads as the synchronized lines ANDed with the normal enables. It is live and drops when either the line or the enable drops.
- R4: The fast pending register at 0x10 reads as the synchronized lines ANDed with the fast enables. It is independent of the normal enables.
- R5: A change on irqLines driven before clock edge E1 appears in a pending read captured at edge E3, but not in one captured at E2. Each access's rspValid, rspErr and rspData appear one clock after the access.
- R6: normReq is the OR of the normal pending bits and fastReq is the OR of the fast pending bits. Each is registered once, so a request follows its pending bits by one clock and follows a line change by three clocks.
- R7: Writing an enable bit for a source whose synchronized line is already high makes it pending on the next read, and the matching request rises one clock after the write edge.
- R8: An access with busSize other than 2'b10 to any mapped register returns rspErr = 1 and has no side effect on either enable register.
- R9: Word writes to the pending registers (0x0C, 0x10) are ignored without error, and pending contents and requests are unchanged.
- R10: An access to an unmapped address returns rspErr = 1 and read data zero, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | NUM_SRC | Level interrupt lines, one per source |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busSize | input | 2 | Transfer size: 00 byte, 01 half, 10 word |
| busWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Response strobe, one clock after busSel |
| rspErr | output | 1 | Error response for a narrow or unmapped access |
| rspData | output | DATA_W | Read data, zero for writes and errors |
| normReq | output | 1 | Normal-class request to the CPU |
| fastReq | output | 1 | Fast-class request to the CPU |

## Verification
The bench builds the block with its defaults: 32 sources, an 8-bit address and a 32-bit data word. With these values every source bit and every mapped offset can be reached, as can the unmapped ones at 0x00 and 0x14. Random line patterns and random enable masks make sources appear in one class, both classes or neither. Directed cases pin down the two-clock synchronizer delay, the one-clock request delay, enabling an already-asserted line, and byte, halfword and unmapped accesses that must leave the enables unchanged.

// File: rtl/irq_dual_router_pkg.sv
package irq_dual_router_pkg;

  localparam logic [7:0] OFS_NORM_EN  = 8'h04;
  localparam logic [7:0] OFS_FAST_EN  = 8'h08;
  localparam logic [7:0] OFS_NORM_PND = 8'h0C;
  localparam logic [7:0] OFS_FAST_PND = 8'h10;
  localparam logic [1:0] SIZE_WORD    = 2'b10;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_NORM_EN,
    RD_FAST_EN,
    RD_NORM_PND,
    RD_FAST_PND
  } rdSel_e;

  typedef struct packed {
    logic   wrNormEn;
    logic   wrFastEn;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_dual_router_ctrl.sv
module irq_dual_router_ctrl
  import irq_dual_router_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output ctrlStrobe_t       strobe,
  output logic              rspValid,
  output logic              rspErr
);

  logic hitNormEn, hitFastEn, hitNormPnd, hitFastPnd;
  logic mapped, isWord, accErr, okAcc;

  always_comb begin
    hitNormEn  = (busAddr == ADDR_W'(OFS_NORM_EN));
    hitFastEn  = (busAddr == ADDR_W'(OFS_FAST_EN));
    hitNormPnd = (busAddr == ADDR_W'(OFS_NORM_PND));
    hitFastPnd = (busAddr == ADDR_W'(OFS_FAST_PND));
    mapped     = hitNormEn | hitFastEn | hitNormPnd | hitFastPnd;
    isWord     = (busSize == SIZE_WORD);
    accErr     = busSel & ~(mapped & isWord);
    okAcc      = busSel & mapped & isWord;

    strobe.wrNormEn = okAcc & busWr & hitNormEn;
    strobe.wrFastEn = okAcc & busWr & hitFastEn;
    strobe.rdSel    = RD_NONE;
    if (okAcc && !busWr) begin
      if (hitNormEn)       strobe.rdSel = RD_NORM_EN;
      else if (hitFastEn)  strobe.rdSel = RD_FAST_EN;
      else if (hitNormPnd) strobe.rdSel = RD_NORM_PND;
      else                 strobe.rdSel = RD_FAST_PND;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= busSel;
      rspErr   <= accErr;
    end
  end

endmodule

// File: rtl/irq_dual_router_dp.sv
module irq_dual_router_dp
  import irq_dual_router_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  logic [DATA_W-1:0]  busWdata,
  input  ctrlStrobe_t        strobe,
  output logic [DATA_W-1:0]  rspData,
  output logic               normReq,
  output logic               fastReq
);

  logic [NUM_SRC-1:0] syncStage [SYNC_STAGES];
  logic [NUM_SRC-1:0] syncLines;
  logic [NUM_SRC-1:0] normEnQ, fastEnQ;
  logic [NUM_SRC-1:0] normPnd, fastPnd;
  logic [DATA_W-1:0]  rdMux;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else if (s == 0) syncStage[s] <= irqLines;
      else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
    end
  end
  assign syncLines = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normEnQ <= '0;
      fastEnQ <= '0;
    end else begin
      if (strobe.wrNormEn) normEnQ <= busWdata[NUM_SRC-1:0];
      if (strobe.wrFastEn) fastEnQ <= busWdata[NUM_SRC-1:0];
    end
  end

  assign normPnd = syncLines & normEnQ;
  assign fastPnd = syncLines & fastEnQ;

  always_comb begin
    rdMux = '0;
    unique case (strobe.rdSel)
      RD_NORM_EN:  rdMux[NUM_SRC-1:0] = normEnQ;
      RD_FAST_EN:  rdMux[NUM_SRC-1:0] = fastEnQ;
      RD_NORM_PND: rdMux[NUM_SRC-1:0] = normPnd;
      RD_FAST_PND: rdMux[NUM_SRC-1:0] = fastPnd;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData <= '0;
      normReq <= 1'b0;
      fastReq <= 1'b0;
    end else begin
      rspData <= rdMux;
      normReq <= |normPnd;
      fastReq <= |fastPnd;
    end
  end

endmodule

// File: rtl/irq_dual_router.sv
module irq_dual_router
  import irq_dual_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [1:0]         busSize,
  input  logic [DATA_W-1:0]  busWdata,
  output logic               rspValid,
  output logic               rspErr,
  output logic [DATA_W-1:0]  rspData,
  output logic               normReq,
  output logic               fastReq
);

  localparam int SYNC_STAGES = 2;

  ctrlStrobe_t strobe;

  irq_dual_router_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busSize(busSize), .strobe(strobe),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  irq_dual_router_dp #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busWdata(busWdata),
    .strobe(strobe), .rspData(rspData), .normReq(normReq), .fastReq(fastReq)
  );

endmodule

// File: rtl/irq_dual_router_chk.sv
module irq_dual_router_chk
  import irq_dual_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqLines,
  input logic               busSel,
  input logic [1:0]         busSize,
  input logic               rspValid,
  input logic               rspErr,
  input logic [DATA_W-1:0]  rspData,
  input logic               normReq,
  input logic               fastReq
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!normReq && !fastReq && !rspValid);
    end
  end

  // R5
  rsp_follows_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel |=> rspValid);

  // R5
  rsp_only_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> !rspValid);

  // R8
  narrow_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busSize != SIZE_WORD) |=> (rspValid && rspErr));

  // R10
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspData == '0));

  // R6
  norm_req_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    normReq |-> $past(|irqLines, 3));

  // R6
  fast_req_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastReq |-> $past(|irqLines, 3));

endmodule

bind irq_dual_router irq_dual_router_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .irqLines(irqLines), .busSel(busSel),
  .busSize(busSize), .rspValid(rspValid), .rspErr(rspErr),
  .rspData(rspData), .normReq(normReq), .fastReq(fastReq)
);

// File: tb/sim_irq_dual_router.sv
`timescale 1ns/1ps
module sim_irq_dual_router;

  localparam int NS = 32;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] irqLines = '0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [1:0]    busSize = 2'b10;
  logic [DW-1:0] busWdata = '0;
  logic          rspValid, rspErr, normReq, fastReq;
  logic [DW-1:0] rspData;

  int testsRun = 0;
  int testsFailed = 0;
  logic [NS-1:0] mNormEn = '0;
  logic [NS-1:0] mFastEn = '0;

  always #10 clk = ~clk;

  irq_dual_router u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busSel(busSel),
    .busWr(busWr), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspData(rspData), .normReq(normReq), .fastReq(fastReq)
  );

  function automatic logic [NS-1:0] expPnd(input logic [NS-1:0] ln,
                                           input logic [NS-1:0] en);
    return ln & en;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] addr,
                        input logic [1:0] size, input logic [DW-1:0] wdata,
                        output logic [DW-1:0] rdata, output logic err);
    busSel = 1'b1; busWr = wr; busAddr = addr; busSize = size; busWdata = wdata;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    rdata = rspData;
    err = rspErr;
    check("R5 rspValid", {31'd0, rspValid}, 32'd1);
  endtask

  task automatic wrReg(input logic [AW-1:0] addr, input logic [DW-1:0] d);
    logic [DW-1:0] rd; logic e;
    access(1'b1, addr, 2'b10, d, rd, e);
    if (addr == 8'h04) mNormEn = d;
    if (addr == 8'h08) mFastEn = d;
  endtask

  task automatic rdCheck(input string req, input logic [AW-1:0] addr,
                         input logic [DW-1:0] exp);
    logic [DW-1:0] rd; logic e;
    access(1'b0, addr, 2'b10, '0, rd, e);
    check(req, rd, exp);
    check({req, " no err"}, {31'd0, e}, 32'd0);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(input string tag);
    rdCheck({tag, " R3 normPnd"}, 8'h0C, expPnd(irqLines, mNormEn));
    rdCheck({tag, " R4 fastPnd"}, 8'h10, expPnd(irqLines, mFastEn));
    check({tag, " R6 normReq"}, {31'd0, normReq}, {31'd0, |expPnd(irqLines, mNormEn)});
    check({tag, " R6 fastReq"}, {31'd0, fastReq}, {31'd0, |expPnd(irqLines, mFastEn)});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] rd; logic e;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 normReq reset", {31'd0, normReq}, 32'd0);
    check("R1 fastReq reset", {31'd0, fastReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    rdCheck("R1 normEn reset", 8'h04, 32'd0);
    rdCheck("R1 fastEn reset", 8'h08, 32'd0);
    rdCheck("R1 normPnd reset", 8'h0C, 32'd0);
    rdCheck("R1 fastPnd reset", 8'h10, 32'd0);

    // R2 readback
    wrReg(8'h04, 32'hA5A5_0F0F);
    wrReg(8'h08, 32'h1234_8001);
    rdCheck("R2 normEn rb", 8'h04, 32'hA5A5_0F0F);
    rdCheck("R2 fastEn rb", 8'h08, 32'h1234_8001);

    // R5 latency: line change visible at E3 not E2; req after E3
    wrReg(8'h04, 32'h0000_0001);
    wrReg(8'h08, 32'h0);
    settle();
    irqLines = 32'h1;
    @(posedge clk); @(negedge clk);
    access(1'b0, 8'h0C, 2'b10, '0, rd, e);
    check("R5 pnd at E2 old", rd, 32'h0);
    check("R5 normReq at E2 low", {31'd0, normReq}, 32'd0);
    access(1'b0, 8'h0C, 2'b10, '0, rd, e);
    check("R5 pnd at E3 new", rd, 32'h1);
    check("R6 normReq after E3", {31'd0, normReq}, 32'd1);
    // R3 live drop on enable clear
    wrReg(8'h04, 32'h0);
    rdCheck("R3 pnd drops with enable", 8'h0C, 32'h0);
    check("R3 normReq drops", {31'd0, normReq}, 32'd0);

    // R7 enable an already asserted line
    irqLines = 32'h0000_0100;
    settle();
    check("R7 fastReq before", {31'd0, fastReq}, 32'd0);
    busSel = 1'b1; busWr = 1'b1; busAddr = 8'h08; busSize = 2'b10;
    busWdata = 32'h0000_0100;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; mFastEn = 32'h0000_0100;
    check("R7 fastReq not yet", {31'd0, fastReq}, 32'd0);
    rdCheck("R7 fast pending at once", 8'h10, 32'h0000_0100);
    check("R7 fastReq rose", {31'd0, fastReq}, 32'd1);

    // R8 narrow accesses
    for (int sz = 0; sz < 2; sz++) begin
      access(1'b1, 8'h04, sz[1:0], 32'hFFFF_FFFF, rd, e);
      check("R8 narrow write err", {31'd0, e}, 32'd1);
      access(1'b1, 8'h08, sz[1:0], 32'hFFFF_FFFF, rd, e);
      check("R8 narrow write err fast", {31'd0, e}, 32'd1);
      access(1'b0, 8'h0C, sz[1:0], '0, rd, e);
      check("R8 narrow read err", {31'd0, e}, 32'd1);
    end
    rdCheck("R8 normEn untouched", 8'h04, mNormEn);
    rdCheck("R8 fastEn untouched", 8'h08, mFastEn);

    // R9 writes to pending ignored
    wrReg(8'h04, 32'h0000_0100);
    settle();
    access(1'b1, 8'h0C, 2'b10, 32'h0, rd, e);
    check("R9 no err normPnd", {31'd0, e}, 32'd0);
    access(1'b1, 8'h10, 2'b10, 32'hFFFF_FFFF, rd, e);
    check("R9 no err fastPnd", {31'd0, e}, 32'd0);
    rdCheck("R9 normPnd kept", 8'h0C, 32'h0000_0100);
    rdCheck("R9 fastPnd kept", 8'h10, 32'h0000_0100);
    check("R9 normReq kept", {31'd0, normReq}, 32'd1);

    // R10 unmapped
    access(1'b1, 8'h00, 2'b10, 32'hFFFF_FFFF, rd, e);
    check("R10 unmapped write err", {31'd0, e}, 32'd1);
    access(1'b0, 8'h14, 2'b10, '0, rd, e);
    check("R10 unmapped read err", {31'd0, e}, 32'd1);
    check("R10 unmapped read zero", rd, 32'h0);
    access(1'b1, 8'h05, 2'b10, 32'hFFFF_FFFF, rd, e);
    check("R10 misaligned err", {31'd0, e}, 32'd1);
    rdCheck("R10 normEn unchanged", 8'h04, mNormEn);
    rdCheck("R10 fastEn unchanged", 8'h08, mFastEn);

    // R3 R4 R6 random patterns
    for (int it = 0; it < 60; it++) begin
      logic [NS-1:0] ln, ne, fe;
      ln = $urandom();
      ne = $urandom();
      fe = $urandom();
      if (it % 5 == 0) ln = '0;
      if (it % 7 == 1) ne = '0;
      if (it % 7 == 2) fe = ~ne;
      if (it % 9 == 3) ln = ne & fe;
      wrReg(8'h04, ne);
      wrReg(8'h08, fe);
      irqLines = ln;
      settle();
      checkAll("rand");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule